// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, cycle by cycle, whether the front of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) may advance. The pipeline has no operand bypass paths, a single memory port that both instruction fetch and data access use, and branches whose outcome is known only when they leave the execute stage. The controller looks at the register fields and instruction-class flags of the occupants of the decode, execute and memory stages. It drives four purely combinational controls that the pipeline registers consume at the next clock edge.

A read-after-write conflict freezes fetch and decode and sends a bubble into execute. Execute and memory keep draining, and the producer eventually reaches write-back. The register file writes early in a cycle and reads late in it, so an instruction in write-back never blocks decode. A load or store in the memory stage takes the shared port, so fetch is held and decode receives a bubble. A branch in decode or execute also holds fetch and puts a bubble into decode. The following instruction therefore reaches decode only after the branch has left execute, which costs two cycles per branch. When several hazards coincide, the data freeze takes precedence. The instruction held in decode then stays where it is, and nothing is dropped or issued twice.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: When a valid decode instruction reads a used source register (source i sits at bits [i*REG_AW +: REG_AW] of `dec_src_addr`, enabled by `dec_src_used[i]`) that equals the non-zero destination of a valid, register-writing execute instruction, the outputs are fetch_hold=1, decode_hold=1, decode_bubble=0, exec_bubble=1.
- R2: The same match against a valid, register-writing memory-stage instruction gives the same output pattern as R1.
- R3: A producer that is no longer in execute or memory (it is in write-back or has retired) causes no stall. A decode instruction whose sources match neither stage gives all four outputs at 0.
- R4: A destination register address of 0 never causes a data stall.
- R5: A source with its used flag clear, a producer with its write flag or valid flag clear, or an invalid decode slot never causes a data stall.
- R6: A valid load or store in the memory stage, with no data stall present, gives fetch_hold=1, decode_bubble=1, decode_hold=0, exec_bubble=0. An invalid memory slot with the load/store flag set has no effect.
- R7: A valid branch in decode or in execute, with no data stall present, gives fetch_hold=1 and decode_bubble=1. A branch that passes through both stages therefore keeps the next instruction out of decode for two consecutive cycles.
- R8: When a data stall coincides with a memory-port conflict or a branch hold, a single freeze applies: fetch_hold=1, decode_hold=1, decode_bubble=0, exec_bubble=1.
- R9: decode_hold and decode_bubble are never both 1. exec_bubble is 1 exactly when decode_hold is 1, and fetch_hold is 1 whenever any other output is 1.
- R10: With no hazard present (including right after reset with idle stages), all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used for property sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_addr | input | NUM_SRC*REG_AW | Packed source register addresses of the decode instruction |
| dec_src_used | input | NUM_SRC | Per-source read enable |
| dec_is_branch | input | 1 | Decode instruction is a branch |
| exe_valid | input | 1 | Execute stage holds a real instruction |
| exe_dst_addr | input | REG_AW | Execute instruction destination register |
| exe_dst_wr | input | 1 | Execute instruction writes a register |
| exe_is_branch | input | 1 | Execute instruction is a branch |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_dst_addr | input | REG_AW | Memory-stage instruction destination register |
| mem_dst_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_ldst | input | 1 | Memory-stage instruction is a load or store |
| fetch_hold | output | 1 | Keep the program counter and fetch stage unchanged |
| decode_hold | output | 1 | Keep the fetch/decode register contents |
| decode_bubble | output | 1 | Load a bubble into the fetch/decode register |
| exec_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The data interlock is tried with the producer in execute, then in memory, then absent. It is tried on the first and on the second source. These cases show that both producer stages and both operands are compared, and that an instruction in write-back is left out. Matches that the zero register, a clear use flag, a clear write flag or an invalid slot must suppress show that each qualifier gates the compare. Port and branch patterns are applied alone and together with a data conflict. This separates the bubble-into-decode response from the freeze response and confirms which one takes precedence. A branch walked from decode into execute and then out confirms exactly two bubble cycles.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef struct packed {
    logic       valid;
    logic       wr;
    logic [4:0] addr;
  } producer_t;

  typedef struct packed {
    logic fetch_hold;
    logic decode_hold;
    logic decode_bubble;
    logic exec_bubble;
  } stall_ctl_t;

  localparam int unsigned PROD_EXE = 0;
  localparam int unsigned PROD_MEM = 1;
  localparam int unsigned NUM_PROD = 2;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned NUM_PROD = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_used,
  input  logic [REG_AW-1:0]          src_addr,
  input  logic [NUM_PROD-1:0]        prod_live,
  input  logic [NUM_PROD*REG_AW-1:0] prod_addr,
  output logic                       conflict
);

  logic [NUM_PROD-1:0] hit;
  logic                src_nonzero;

  always_comb src_nonzero = |src_addr;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    always_comb
      hit[p] = prod_live[p] && (prod_addr[p*REG_AW +: REG_AW] == src_addr);
  end

  always_comb conflict = src_used && src_nonzero && (|hit);

  // R4: register zero never produces a conflict
  a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (src_addr == '0) |-> !conflict);
  // R5: an unused source never conflicts
  a_r5_unused_src: assert property (@(posedge clk) disable iff (!rst_n)
    !src_used |-> !conflict);

endmodule

// File: rtl/hz_data_interlock.sv
module hz_data_interlock
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_valid,
  input  logic [NUM_SRC*REG_AW-1:0] dec_src_addr,
  input  logic [NUM_SRC-1:0]        dec_src_used,
  input  logic                      exe_valid,
  input  logic                      exe_wr,
  input  logic [REG_AW-1:0]         exe_addr,
  input  logic                      mem_valid,
  input  logic                      mem_wr,
  input  logic [REG_AW-1:0]         mem_addr,
  output logic                      raw_stall
);

  localparam int unsigned PW = NUM_PROD * REG_AW;

  logic [NUM_PROD-1:0] prod_live;
  logic [PW-1:0]       prod_addr;
  logic [NUM_SRC-1:0]  src_conflict;

  always_comb begin
    prod_live           = '0;
    prod_addr           = '0;
    prod_live[PROD_EXE] = exe_valid && exe_wr;
    prod_live[PROD_MEM] = mem_valid && mem_wr;
    prod_addr[PROD_EXE*REG_AW +: REG_AW] = exe_addr;
    prod_addr[PROD_MEM*REG_AW +: REG_AW] = mem_addr;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_src_match #(
      .REG_AW  (REG_AW),
      .NUM_PROD(NUM_PROD)
    ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_used (dec_src_used[s]),
      .src_addr (dec_src_addr[s*REG_AW +: REG_AW]),
      .prod_live(prod_live),
      .prod_addr(prod_addr),
      .conflict (src_conflict[s])
    );
  end

  always_comb raw_stall = dec_valid && (|src_conflict);

  // R5: an empty decode slot or idle producers never interlock
  a_r5_no_producer: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || (!(exe_valid && exe_wr) && !(mem_valid && mem_wr))) |-> !raw_stall);

endmodule

// File: rtl/hz_front_block.sv
module hz_front_block (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_valid,
  input  logic dec_is_branch,
  input  logic exe_valid,
  input  logic exe_is_branch,
  input  logic mem_valid,
  input  logic mem_is_ldst,
  output logic port_busy,
  output logic branch_wait
);

  always_comb begin
    port_busy   = mem_valid && mem_is_ldst;
    branch_wait = (dec_valid && dec_is_branch) || (exe_valid && exe_is_branch);
  end

  // R6: an empty memory slot never claims the port
  a_r6_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !port_busy);
  // R7: no branch present means no branch wait
  a_r7_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_is_branch && !exe_is_branch) |-> !branch_wait);

endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_valid,
  input  logic [NUM_SRC*REG_AW-1:0] dec_src_addr,
  input  logic [NUM_SRC-1:0]        dec_src_used,
  input  logic                      dec_is_branch,
  input  logic                      exe_valid,
  input  logic [REG_AW-1:0]         exe_dst_addr,
  input  logic                      exe_dst_wr,
  input  logic                      exe_is_branch,
  input  logic                      mem_valid,
  input  logic [REG_AW-1:0]         mem_dst_addr,
  input  logic                      mem_dst_wr,
  input  logic                      mem_is_ldst,
  output logic                      fetch_hold,
  output logic                      decode_hold,
  output logic                      decode_bubble,
  output logic                      exec_bubble
);

  logic       raw_stall;
  logic       port_busy;
  logic       branch_wait;
  stall_ctl_t ctl;

  hz_data_interlock #(
    .REG_AW (REG_AW),
    .NUM_SRC(NUM_SRC)
  ) u_raw (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_src_addr(dec_src_addr),
    .dec_src_used(dec_src_used),
    .exe_valid   (exe_valid),
    .exe_wr      (exe_dst_wr),
    .exe_addr    (exe_dst_addr),
    .mem_valid   (mem_valid),
    .mem_wr      (mem_dst_wr),
    .mem_addr    (mem_dst_addr),
    .raw_stall   (raw_stall)
  );

  hz_front_block u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_is_branch(dec_is_branch),
    .exe_valid    (exe_valid),
    .exe_is_branch(exe_is_branch),
    .mem_valid    (mem_valid),
    .mem_is_ldst  (mem_is_ldst),
    .port_busy    (port_busy),
    .branch_wait  (branch_wait)
  );

  // The data freeze dominates: the decode occupant stays put, so the
  // front-end bubble is suppressed and fetch is held regardless.
  always_comb begin
    ctl               = '0;
    ctl.fetch_hold    = raw_stall || port_busy || branch_wait;
    ctl.decode_hold   = raw_stall;
    ctl.exec_bubble   = raw_stall;
    ctl.decode_bubble = !raw_stall && (port_busy || branch_wait);
  end

  assign fetch_hold    = ctl.fetch_hold;
  assign decode_hold   = ctl.decode_hold;
  assign decode_bubble = ctl.decode_bubble;
  assign exec_bubble   = ctl.exec_bubble;

  // R9: decode is either held or refilled with a bubble, never both
  a_r9_hold_xor_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !(decode_hold && decode_bubble));
  // R9: any stall action implies fetch is frozen
  a_r9_fetch_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_hold || decode_bubble || exec_bubble) |-> fetch_hold);
  // R6: a memory access in flight always blocks fetch
  a_r6_port_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_is_ldst) |-> fetch_hold);
  // R7: a branch in decode or execute keeps the follower out of decode
  a_r7_branch_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_valid && dec_is_branch) || (exe_valid && exe_is_branch))
      |-> (decode_bubble || decode_hold));
  // R1: a live execute-stage match on source 0 freezes decode
  a_r1_exe_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_src_used[0] && exe_valid && exe_dst_wr &&
     (exe_dst_addr != '0) && (dec_src_addr[REG_AW-1:0] == exe_dst_addr))
      |-> (decode_hold && exec_bubble));
  // R2: a live memory-stage match on source 0 freezes decode
  a_r2_mem_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_src_used[0] && mem_valid && mem_dst_wr &&
     (mem_dst_addr != '0) && (dec_src_addr[REG_AW-1:0] == mem_dst_addr))
      |-> (decode_hold && exec_bubble));

endmodule

// File: tb/hazard_stall_ctrl_test.sv
module hazard_stall_ctrl_test;

  localparam int unsigned AW = 5;
  localparam int unsigned NS = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dec_valid;
  logic [NS*AW-1:0] dec_src_addr;
  logic [NS-1:0] dec_src_used;
  logic          dec_is_branch;
  logic          exe_valid;
  logic [AW-1:0] exe_dst_addr;
  logic          exe_dst_wr;
  logic          exe_is_branch;
  logic          mem_valid;
  logic [AW-1:0] mem_dst_addr;
  logic          mem_dst_wr;
  logic          mem_is_ldst;
  logic          fetch_hold, decode_hold, decode_bubble, exec_bubble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  hazard_stall_ctrl #(.REG_AW(AW), .NUM_SRC(NS)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_src_addr(dec_src_addr),
    .dec_src_used(dec_src_used), .dec_is_branch(dec_is_branch),
    .exe_valid(exe_valid), .exe_dst_addr(exe_dst_addr),
    .exe_dst_wr(exe_dst_wr), .exe_is_branch(exe_is_branch),
    .mem_valid(mem_valid), .mem_dst_addr(mem_dst_addr),
    .mem_dst_wr(mem_dst_wr), .mem_is_ldst(mem_is_ldst),
    .fetch_hold(fetch_hold), .decode_hold(decode_hold),
    .decode_bubble(decode_bubble), .exec_bubble(exec_bubble)
  );

  // expected codes {fetch_hold, decode_hold, decode_bubble, exec_bubble}
  localparam logic [3:0] IDLE   = 4'b0000;
  localparam logic [3:0] FREEZE = 4'b1101;
  localparam logic [3:0] REFILL = 4'b1010;

  task automatic idle_stages();
    dec_valid = 1'b0; dec_src_addr = '0; dec_src_used = '0; dec_is_branch = 1'b0;
    exe_valid = 1'b0; exe_dst_addr = '0; exe_dst_wr = 1'b0; exe_is_branch = 1'b0;
    mem_valid = 1'b0; mem_dst_addr = '0; mem_dst_wr = 1'b0; mem_is_ldst = 1'b0;
  endtask

  task automatic set_dec(input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                         input logic [1:0] used);
    dec_valid = 1'b1;
    dec_src_addr = {s1, s0};
    dec_src_used = used;
  endtask

  // driver: inputs already staged by caller, push expectation for this cycle
  task automatic apply(input logic [3:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor: compare in the middle of each cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [3:0] act;
        logic [3:0] exp;
        string      tag;
        act = {fetch_hold, decode_hold, decode_bubble, exec_bubble};
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        n_checks++;
        if (act !== exp) begin
          n_fail++;
          $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
        if (decode_hold && decode_bubble) begin
          n_fail++;
          $display("FAIL R9: actual hold=1 bubble=1 expected not both");
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_stages();
    repeat (3) @(posedge clk);
    #1;
    apply(IDLE, "R10 reset idle");
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: execute producer, source 0 and then source 1
    idle_stages(); set_dec(5'd3, 5'd9, 2'b11);
    exe_valid = 1; exe_dst_wr = 1; exe_dst_addr = 5'd3;
    apply(FREEZE, "R1 exe src0");
    exe_dst_addr = 5'd9;
    apply(FREEZE, "R1 exe src1");

    // R2: memory-stage producer
    idle_stages(); set_dec(5'd4, 5'd17, 2'b11);
    mem_valid = 1; mem_dst_wr = 1; mem_dst_addr = 5'd17;
    apply(FREEZE, "R2 mem src1");

    // R3: producer gone from both stages (already in write-back)
    idle_stages(); set_dec(5'd4, 5'd5, 2'b11);
    exe_valid = 1; exe_dst_wr = 1; exe_dst_addr = 5'd6;
    mem_valid = 1; mem_dst_wr = 1; mem_dst_addr = 5'd7;
    apply(IDLE, "R3 no match");

    // R4: register zero
    idle_stages(); set_dec(5'd0, 5'd0, 2'b11);
    exe_valid = 1; exe_dst_wr = 1; exe_dst_addr = 5'd0;
    mem_valid = 1; mem_dst_wr = 1; mem_dst_addr = 5'd0;
    apply(IDLE, "R4 zero reg");

    // R5: qualifiers
    idle_stages(); set_dec(5'd8, 5'd8, 2'b00);
    exe_valid = 1; exe_dst_wr = 1; exe_dst_addr = 5'd8;
    apply(IDLE, "R5 unused src");
    set_dec(5'd8, 5'd8, 2'b01); exe_dst_wr = 0;
    apply(IDLE, "R5 no write");
    exe_dst_wr = 1; exe_valid = 0;
    apply(IDLE, "R5 exe invalid");
    exe_valid = 1; dec_valid = 0;
    apply(IDLE, "R5 dec invalid");

    // R6: shared memory port
    idle_stages(); set_dec(5'd1, 5'd2, 2'b11);
    mem_valid = 1; mem_is_ldst = 1; mem_dst_addr = 5'd20; mem_dst_wr = 1;
    apply(REFILL, "R6 ldst in mem");
    mem_valid = 0;
    apply(IDLE, "R6 invalid mem slot");

    // R7: branch walks decode -> execute -> gone; two bubble cycles
    idle_stages(); set_dec(5'd1, 5'd2, 2'b11); dec_is_branch = 1;
    apply(REFILL, "R7 branch in decode");
    idle_stages(); exe_valid = 1; exe_is_branch = 1;
    apply(REFILL, "R7 branch in execute");
    idle_stages(); set_dec(5'd1, 5'd2, 2'b11);
    apply(IDLE, "R7 branch resolved");

    // R8: combined hazards
    idle_stages(); set_dec(5'd11, 5'd0, 2'b01);
    mem_valid = 1; mem_is_ldst = 1; mem_dst_wr = 1; mem_dst_addr = 5'd11;
    apply(FREEZE, "R8 raw plus port");
    idle_stages(); set_dec(5'd12, 5'd0, 2'b01); dec_is_branch = 1;
    exe_valid = 1; exe_dst_wr = 1; exe_dst_addr = 5'd12;
    apply(FREEZE, "R8 raw plus branch");

    // R9: port conflict alone leaves exec untouched and decode unheld
    idle_stages(); mem_valid = 1; mem_is_ldst = 1;
    apply(REFILL, "R9 refill only");

    idle_stages();
    apply(IDLE, "R10 quiet");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule